// File: doc/BRIEF.md
# Eight-pin GPIO port with change-detect SMI request

The block is one general-purpose I/O port of eight pins. A small indexed register interface lets software set each pin's drive direction and output value and read back the live pin state. Each pin also has an interrupt-enable bit and a sticky change flag. While a pin is an input, the flag is set by every level change on the pin, whether rising or falling. Software clears a flag by writing a one to it.

Every pin whose flag and enable are both set raises a single system-management request. A route-select input sends that request either to a power-management event output or to a serial-interrupt request line. The other line stays low.

Pad inputs pass through a two-stage synchroniser before they are used. Register reads are combinational from the current index. Writes take effect on the next rising clock edge.

Top module: `gpio_smi_port`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0, and pad_o, pad_oe_o, pme_o and sirq_req_o are all 0.
- R2: Index 0 is the direction register, where bit n = 1 makes pin n an output. Index 1 is the output data register. Both can be written and read back, and pad_oe_o and pad_o follow them one clock after the write.
- R3: Index 2 is read-only pin state. Bit n returns the driven output data when pin n is an output. Otherwise it returns the pad level, which appears two rising edges after the pad changes. Writes to index 2 have no effect.
- R4: A level change in either direction on an input pin sets bit n of the change-flag register at index 5. The flag is visible after the third rising edge that follows the pad change.
- R5: A pin that is an output never sets its change flag, whatever its pad input does.
- R6: Writing to index 5 clears each flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0.
- R7: If a new change is detected on the same edge that clears that pin's flag, the flag stays 1.
- R8: Index 4 is the per-pin request enable. The request is active exactly when some pin has both its flag and its enable set, so a pin with enable 0 never raises it.
- R9: With route_sirq_i = 0 the request appears on pme_o. With route_sirq_i = 1 it appears on sirq_req_o. The unselected line is always 0.
- R10: Indices 3, 6 and 7 read as 0, and writes to them change no register or output.
- R11: A single pad change sets its flag only once. A flag cleared while the pad stays steady remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register index |
| wr_en_i | input | 1 | Write strobe for the indexed register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the indexed register |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output data |
| pad_oe_o | output | 8 | Pad output enables |
| route_sirq_i | input | 1 | Request route: 0 to pme_o, 1 to sirq_req_o |
| pme_o | output | 1 | Power-management event request |
| sirq_req_o | output | 1 | Serial-interrupt request |

## Verification
The hardest case to reach is a pad change whose detection lands on the very edge where software clears the same flag. Producing it needs the pad toggle and the clear write spaced exactly by the synchroniser depth. A directed sequence places the toggle and then issues the clear two cycles later.

Random traffic mixes pad toggles with writes to every index. Some of those writes flip a pin's direction while a change is still in the synchroniser, which exercises the input-mode gating at the moment of detection.

// File: rtl/gpio_smi_pkg.sv
package gpio_smi_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_DIR  = 3'd0,
    IDX_DOUT = 3'd1,
    IDX_PIN  = 3'd2,
    IDX_IEN  = 3'd4,
    IDX_FLAG = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] dir_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    // only input pins detect
    assign chg_o[i] = (sync_i[i] ^ prev_q[i]) & ~dir_i[i];
  end
endmodule

// File: rtl/gpio_smi_regs.sv
module gpio_smi_regs
  import gpio_smi_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] addr_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] chg_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] ien_o,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] dir_q, dout_q, ien_q, flag_q;
  logic [WIDTH-1:0] clr;
  logic [WIDTH-1:0] pin_view;

  assign clr = (wr_en_i && addr_i == IDX_FLAG) ? wr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == IDX_DIR)  dir_q  <= wr_data_i;
      if (addr_i == IDX_DOUT) dout_q <= wr_data_i;
      if (addr_i == IDX_IEN)  ien_q  <= wr_data_i;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (chg_i[i]) flag_q[i] <= 1'b1;  // set beats clear
      else if (clr[i])   flag_q[i] <= 1'b0;
    end
    assign pin_view[i] = dir_q[i] ? dout_q[i] : sync_i[i];
  end

  always_comb begin
    unique case (addr_i)
      IDX_DIR:  rd_data_o = dir_q;
      IDX_DOUT: rd_data_o = dout_q;
      IDX_PIN:  rd_data_o = pin_view;
      IDX_IEN:  rd_data_o = ien_q;
      IDX_FLAG: rd_data_o = flag_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign ien_o  = ien_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_smi_req.sv
module gpio_smi_req #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] ien_i,
  input  logic             route_sirq_i,
  output logic             pme_o,
  output logic             sirq_req_o
);
  logic req;

  assign req        = |(flag_i & ien_i);
  assign pme_o      = req & ~route_sirq_i;
  assign sirq_req_o = req &  route_sirq_i;
endmodule

// File: rtl/gpio_smi_port.sv
module gpio_smi_port
  import gpio_smi_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              wr_en_i,
  input  logic [N_PINS-1:0] wr_data_i,
  output logic [N_PINS-1:0] rd_data_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  input  logic              route_sirq_i,
  output logic              pme_o,
  output logic              sirq_req_o
);
  logic [N_PINS-1:0] sync_w, chg_w, dir_w, dout_w, ien_w, flag_w;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(sync_w)
  );

  gpio_chg_det #(.WIDTH(N_PINS)) u_det (
    .clk_i, .rst_ni, .sync_i(sync_w), .dir_i(dir_w), .chg_o(chg_w)
  );

  gpio_smi_regs #(.WIDTH(N_PINS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i,
    .sync_i(sync_w), .chg_i(chg_w), .rd_data_o,
    .dir_o(dir_w), .dout_o(dout_w), .ien_o(ien_w), .flag_o(flag_w)
  );

  gpio_smi_req #(.WIDTH(N_PINS)) u_req (
    .flag_i(flag_w), .ien_i(ien_w), .route_sirq_i, .pme_o, .sirq_req_o
  );

  assign pad_o    = dout_w;
  assign pad_oe_o = dir_w;
endmodule

// File: rtl/gpio_smi_port_chk.sv
module gpio_smi_port_chk
  import gpio_smi_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  addr_i,
  input logic              wr_en_i,
  input logic [N_PINS-1:0] wr_data_i,
  input logic [N_PINS-1:0] pad_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              pme_o,
  input logic              sirq_req_o,
  input logic [N_PINS-1:0] chg_w,
  input logic [N_PINS-1:0] ien_w,
  input logic [N_PINS-1:0] flag_w
);
  // R9
  one_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pme_o && sirq_req_o));

  // R8
  masked_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_w == '0) |-> !(pme_o || sirq_req_o));

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_DIR) |=> pad_oe_o == $past(wr_data_i));

  // R6
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_FLAG) |=>
      (flag_w & $past(wr_data_i & ~chg_w)) == '0);

  // R5
  out_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_w & ~$past(flag_w)) & $past(pad_oe_o)) == '0);

  // R3
  pin_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_PIN) |=> $stable(pad_o) && $stable(pad_oe_o));
endmodule

bind gpio_smi_port gpio_smi_port_chk #(.N_PINS(N_PINS)) u_chk (.*);

// File: tb/gpio_smi_port_tb.sv
module gpio_smi_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] pad = '0;
  logic [7:0] pad_out, pad_oe;
  logic       route = 1'b0;
  logic       pme, sirq;

  int unsigned n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_smi_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .pad_i(pad), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .route_sirq_i(route), .pme_o(pme), .sirq_req_o(sirq)
  );

  // reference model from the requirements: flag visible after 3rd edge
  logic [7:0] m_dir, m_dout, m_ien, m_flag, p1, p2, p3, det;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_dout = '0; m_ien = '0; m_flag = '0;
      p1 = '0; p2 = '0; p3 = '0;
    end else begin
      det = (p2 ^ p3) & ~m_dir;
      if (wr_en) begin
        if (addr == 3'd0) m_dir  = wr_data;
        if (addr == 3'd1) m_dout = wr_data;
        if (addr == 3'd4) m_ien  = wr_data;
      end
      m_flag = (m_flag & ~((wr_en && addr == 3'd5) ? wr_data : 8'h00)) | det;
      p3 = p2; p2 = p1; p1 = pad;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_dout;
      3'd2: return (m_dir & m_dout) | (~m_dir & p2);
      3'd4: return m_ien;
      3'd5: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd4: return "R8";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic w, input logic [7:0] d,
                      input logic [7:0] p);
    @(negedge clk);
    addr = a; wr_en = w; wr_data = d; pad = p;
    #1;
    check(tag(a), rd_data, exp_rd(a));
    check("R2", pad_out, m_dout);
    check("R2", pad_oe, m_dir);
    check("R9", {pme, sirq}, {(|(m_flag & m_ien)) & ~route, (|(m_flag & m_ien)) & route});
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
    step(a, 1'b0, 8'h00, pad);
    check(req, rd_data, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check("R1", {pad_out, pad_oe, 6'b0, pme, sirq}, 24'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a), "R1", 8'h00);

    // R2 direction and data
    step(3'd0, 1'b1, 8'hF0, 8'h00);
    step(3'd1, 1'b1, 8'hA5, 8'h00);
    rd(3'd0, "R2", 8'hF0);
    rd(3'd1, "R2", 8'hA5);
    // R3 / R4 / R5: pins 2,3 (input) and 4,5 (output) toggle
    step(3'd5, 1'b0, 8'h00, 8'h3C);
    step(3'd5, 1'b0, 8'h00, 8'h3C);
    rd(3'd2, "R3", 8'hAC);
    rd(3'd5, "R4", 8'h0C);
    rd(3'd5, "R5", 8'h0C);
    // R3 write to pin state ignored
    step(3'd2, 1'b1, 8'h00, 8'h3C);
    rd(3'd2, "R3", 8'hAC);
    // R6 write-one-to-clear
    step(3'd5, 1'b1, 8'h04, 8'h3C);
    rd(3'd5, "R6", 8'h08);
    step(3'd5, 1'b1, 8'h00, 8'h3C);
    rd(3'd5, "R6", 8'h08);
    // R8 / R9 routing
    step(3'd4, 1'b1, 8'h08, 8'h3C);
    rd(3'd4, "R8", 8'h08);
    check("R9", {pme, sirq}, 2'b10);
    route = 1'b1;
    rd(3'd5, "R9", 8'h08);
    check("R9", {pme, sirq}, 2'b01);
    step(3'd4, 1'b1, 8'h04, 8'h3C);
    rd(3'd4, "R8", 8'h04);
    check("R8", {pme, sirq}, 2'b00);
    route = 1'b0;
    // R7 set beats clear on the same edge (pin 0 rises)
    step(3'd5, 1'b0, 8'h00, 8'h3D);
    step(3'd5, 1'b0, 8'h00, 8'h3D);
    step(3'd5, 1'b1, 8'h01, 8'h3D);
    rd(3'd5, "R7", 8'h09);
    // R11 one detection per change
    step(3'd5, 1'b1, 8'h09, 8'h3D);
    rd(3'd5, "R11", 8'h00);
    repeat (4) step(3'd5, 1'b0, 8'h00, 8'h3D);
    rd(3'd5, "R11", 8'h00);
    // R10 unused indices
    step(3'd3, 1'b1, 8'hFF, 8'h3D);
    step(3'd6, 1'b1, 8'hFF, 8'h3D);
    step(3'd7, 1'b1, 8'hFF, 8'h3D);
    rd(3'd6, "R10", 8'h00);
    rd(3'd0, "R10", 8'hF0);
    rd(3'd1, "R10", 8'hA5);
    rd(3'd4, "R10", 8'h04);

    // random mix, every step checked against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic       w;
      logic [7:0] d, p;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      p = ($urandom_range(0, 2) == 0) ? (pad ^ (8'd1 << $urandom_range(0, 7))) : pad;
      if ($urandom_range(0, 15) == 0) route = ~route;
      step(a, w, d, p);
    end
    finish_run();
  end
endmodule